// File: doc/BRIEF.md
# Hardwired Datapath Control Decoder

This block is the control unit of a single-cycle datapath that has separate instruction and data memories. It is purely combinational. From the 6-bit primary opcode, the 6-bit function field and the ALU zero flag, it produces every select line the datapath needs for one instruction:

- the immediate extension mode
- the ALU second-operand source
- the ALU operation source
- the data-memory write enable
- the register-file write enable
- the write-back source
- the destination register choice
- the next-PC source

The decode runs in two steps. First, a classifier reduces the opcode and function field to one instruction kind. Second, a per-kind table supplies the data-path selects, and a separate next-PC selector combines the kind with the zero flag. Any encoding that is not recognised becomes a "none" kind. That kind writes nothing and falls through to the sequential PC. Every select that an instruction does not use is driven to code 0.

The block has no state and no clock, so the house state-machine layout does not apply. The instruction kinds play the part of states. They are: none, register ALU, signed-immediate ALU, unsigned-immediate ALU, load, store, branch-on-zero, jump, jump-and-link, register jump, and register jump-and-link. The only "transition" is the next-PC choice, which is fixed per kind except for branch-on-zero: it takes the branch target when zero is 1 and the sequential PC when zero is 0.

Top module: `ctl_decoder`

## Requirements
Output codes used throughout:

| Output | Codes |
|---|---|
| ext_sel | 0 sign-extend, 1 zero-extend |
| b_sel | 0 register, 1 immediate |
| alu_sel | 00 add, 01 from function field, 10 from opcode, 11 zero test |
| wb_sel | 00 ALU, 01 memory, 10 PC |
| dst_sel | 00 rt, 01 rd, 10 link register 31 |
| pc_sel | 00 PC+4, 01 branch target, 10 register target, 11 absolute target |

- R1: Opcode 000000 with funct[5]=1 (register ALU) gives ext_sel=0, b_sel=0, alu_sel=01, mem_we=0, reg_we=1, wb_sel=00, dst_sel=01, pc_sel=00.
- R2: Opcodes 001000 to 001011 (signed immediate ALU) give ext_sel=0, b_sel=1, alu_sel=10, mem_we=0, reg_we=1, wb_sel=00, dst_sel=00, pc_sel=00.
- R3: Opcodes 001100 to 001111 (unsigned immediate ALU) give the same outputs as R2, except ext_sel=1.
- R4: Opcode 100011 (load) gives ext_sel=0, b_sel=1, alu_sel=00, mem_we=0, reg_we=1, wb_sel=01, dst_sel=00, pc_sel=00.
- R5: Opcode 101011 (store) gives ext_sel=0, b_sel=1, alu_sel=00, mem_we=1, reg_we=0, wb_sel=00, dst_sel=00, pc_sel=00.
- R6: Opcode 000100 (branch-on-zero) gives ext_sel=0, b_sel=0, alu_sel=11, and no writes. pc_sel is 01 when zero=1 and 00 when zero=0.
- R7: Opcode 000010 (jump) gives pc_sel=11 with no writes. Opcode 000011 (jump-and-link) gives pc_sel=11, reg_we=1, wb_sel=10, dst_sel=10.
- R8: Opcode 000000 with funct 001000 (register jump) gives pc_sel=10 with no writes. Funct 001001 (register jump-and-link) gives pc_sel=10, reg_we=1, wb_sel=10, dst_sel=10.
- R9: Every other opcode or function value drives all outputs to 0. That means no writes and pc_sel=00.
- R10: mem_we and reg_we are never both 1. Whenever reg_we=0, wb_sel and dst_sel are 00. Whenever wb_sel=10, dst_sel is 10.
- R11: The zero flag affects no output except pc_sel, and only when the opcode is branch-on-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Primary opcode field |
| funct | input | 6 | Function field, used when opcode is 000000 |
| zero | input | 1 | ALU zero flag |
| ext_sel | output | 1 | Immediate extension mode |
| b_sel | output | 1 | ALU second-operand source |
| alu_sel | output | 2 | ALU operation source |
| mem_we | output | 1 | Data-memory write enable |
| reg_we | output | 1 | Register-file write enable |
| wb_sel | output | 2 | Write-back source |
| dst_sel | output | 2 | Destination register choice |
| pc_sel | output | 2 | Next-PC source |

## Verification
The assertions inside the decoder check, for every input combination, the properties that hold across kinds:

- the two write enables are exclusive
- unused write-back and destination selects are zero when no register is written
- a PC write-back always targets the link register
- the branch follows the zero flag
- a store always enables a memory write

Whether each individual encoding lands in the right kind, with exactly the right full control word, can only be shown by the bench's scenarios. The bench sweeps every opcode, a wide set of function values and both zero values against its own reference model, and adds directed checks on the kind boundaries.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int OP_W  = 6;
    localparam int FN_W  = 6;
    localparam int SEL_W = 2;

    localparam logic [OP_W-1:0] OPC_SPECIAL = 6'b000000;
    localparam logic [OP_W-1:0] OPC_JMP     = 6'b000010;
    localparam logic [OP_W-1:0] OPC_JMPL    = 6'b000011;
    localparam logic [OP_W-1:0] OPC_BRZ     = 6'b000100;
    localparam logic [OP_W-1:0] OPC_LOAD    = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE   = 6'b101011;

    localparam logic [FN_W-1:0] FN_RJMP     = 6'b001000;
    localparam logic [FN_W-1:0] FN_RJMPL    = 6'b001001;

    typedef enum logic [3:0] {
        K_NONE, K_RALU, K_IALU_S, K_IALU_U, K_LOAD, K_STORE,
        K_BRZ, K_JMP, K_JMPL, K_RJMP, K_RJMPL
    } kind_e;

    typedef enum logic       { EXT_SIGN = 1'b0, EXT_ZERO = 1'b1 } ext_e;
    typedef enum logic       { BSRC_REG = 1'b0, BSRC_IMM = 1'b1 } bsrc_e;
    typedef enum logic [SEL_W-1:0] {
        ALU_ADD = 2'b00, ALU_FN = 2'b01, ALU_OP = 2'b10, ALU_ZT = 2'b11
    } alusel_e;
    typedef enum logic [SEL_W-1:0] {
        WB_ALU = 2'b00, WB_MEM = 2'b01, WB_PC = 2'b10
    } wbsel_e;
    typedef enum logic [SEL_W-1:0] {
        DST_RT = 2'b00, DST_RD = 2'b01, DST_LINK = 2'b10
    } dstsel_e;
    typedef enum logic [SEL_W-1:0] {
        PC_SEQ = 2'b00, PC_BR = 2'b01, PC_REG = 2'b10, PC_ABS = 2'b11
    } pcsel_e;

    typedef struct packed {
        ext_e    ext;
        bsrc_e   bsrc;
        alusel_e alu;
        logic    mem_we;
        logic    reg_we;
        wbsel_e  wb;
        dstsel_e dst;
    } dpctl_t;

endpackage

// File: rtl/ctl_classify.sv
module ctl_classify
    import ctl_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    input  logic [FN_W-1:0] funct,
    output kind_e           kind
);
    always_comb begin
        kind = K_NONE;
        unique casez (opcode)
            OPC_SPECIAL: begin
                if (funct[FN_W-1])        kind = K_RALU;
                else if (funct == FN_RJMP)  kind = K_RJMP;
                else if (funct == FN_RJMPL) kind = K_RJMPL;
                else                        kind = K_NONE;
            end
            6'b0010??: kind = K_IALU_S;
            6'b0011??: kind = K_IALU_U;
            OPC_LOAD:  kind = K_LOAD;
            OPC_STORE: kind = K_STORE;
            OPC_BRZ:   kind = K_BRZ;
            OPC_JMP:   kind = K_JMP;
            OPC_JMPL:  kind = K_JMPL;
            default:   kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/ctl_table.sv
module ctl_table
    import ctl_pkg::*;
(
    input  kind_e  kind,
    output dpctl_t ctl
);
    always_comb begin
        ctl = '{ext: EXT_SIGN, bsrc: BSRC_REG, alu: ALU_ADD, mem_we: 1'b0,
                reg_we: 1'b0, wb: WB_ALU, dst: DST_RT};
        unique case (kind)
            K_RALU: begin
                ctl.alu    = ALU_FN;
                ctl.reg_we = 1'b1;
                ctl.dst    = DST_RD;
            end
            K_IALU_S, K_IALU_U: begin
                ctl.ext    = (kind == K_IALU_U) ? EXT_ZERO : EXT_SIGN;
                ctl.bsrc   = BSRC_IMM;
                ctl.alu    = ALU_OP;
                ctl.reg_we = 1'b1;
            end
            K_LOAD: begin
                ctl.bsrc   = BSRC_IMM;
                ctl.reg_we = 1'b1;
                ctl.wb     = WB_MEM;
            end
            K_STORE: begin
                ctl.bsrc   = BSRC_IMM;
                ctl.mem_we = 1'b1;
            end
            K_BRZ: begin
                ctl.alu    = ALU_ZT;
            end
            K_JMPL, K_RJMPL: begin
                ctl.reg_we = 1'b1;
                ctl.wb     = WB_PC;
                ctl.dst    = DST_LINK;
            end
            K_NONE, K_JMP, K_RJMP: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/ctl_next_pc.sv
module ctl_next_pc
    import ctl_pkg::*;
(
    input  kind_e  kind,
    input  logic   zero,
    output pcsel_e pc
);
    always_comb begin
        unique case (kind)
            K_BRZ:           pc = zero ? PC_BR : PC_SEQ;
            K_JMP, K_JMPL:   pc = PC_ABS;
            K_RJMP, K_RJMPL: pc = PC_REG;
            default:         pc = PC_SEQ;
        endcase
    end
endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
    import ctl_pkg::*;
(
    input  logic [OP_W-1:0]  opcode,
    input  logic [FN_W-1:0]  funct,
    input  logic             zero,
    output logic             ext_sel,
    output logic             b_sel,
    output logic [SEL_W-1:0] alu_sel,
    output logic             mem_we,
    output logic             reg_we,
    output logic [SEL_W-1:0] wb_sel,
    output logic [SEL_W-1:0] dst_sel,
    output logic [SEL_W-1:0] pc_sel
);
    kind_e  kind;
    dpctl_t ctl;
    pcsel_e pc;

    ctl_classify u_classify (.opcode(opcode), .funct(funct), .kind(kind));
    ctl_table    u_table    (.kind(kind), .ctl(ctl));
    ctl_next_pc  u_next_pc  (.kind(kind), .zero(zero), .pc(pc));

    assign ext_sel = ctl.ext;
    assign b_sel   = ctl.bsrc;
    assign alu_sel = ctl.alu;
    assign mem_we  = ctl.mem_we;
    assign reg_we  = ctl.reg_we;
    assign wb_sel  = ctl.wb;
    assign dst_sel = ctl.dst;
    assign pc_sel  = pc;

    // Cross-kind properties, checked whenever the inputs settle
    always_comb begin
        p_we_excl_r10: assert (!(mem_we && reg_we))
            else $error("both write enables high");
        p_idle_sel_r10: assert (reg_we || (wb_sel == 2'b00 && dst_sel == 2'b00))
            else $error("unused write-back selects not zero");
        p_link_r7: assert (wb_sel != 2'b10 || dst_sel == 2'b10)
            else $error("PC write-back without link register");
        p_branch_r6: assert (opcode != OPC_BRZ || pc_sel == (zero ? 2'b01 : 2'b00))
            else $error("branch does not follow zero flag");
        p_store_r5: assert (opcode != OPC_STORE || (mem_we && !reg_we))
            else $error("store write enables wrong");
    end
endmodule

// File: tb/test_ctl_decoder.sv
module test_ctl_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = '0;
    logic [5:0] funct = '0;
    logic       zero = 1'b0;
    logic       ext_sel, b_sel, mem_we, reg_we;
    logic [1:0] alu_sel, wb_sel, dst_sel, pc_sel;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ctl_decoder i_ctl_decoder (
        .opcode(opcode), .funct(funct), .zero(zero),
        .ext_sel(ext_sel), .b_sel(b_sel), .alu_sel(alu_sel),
        .mem_we(mem_we), .reg_we(reg_we), .wb_sel(wb_sel),
        .dst_sel(dst_sel), .pc_sel(pc_sel)
    );

    // Control word layout: {ext, b, alu[1:0], mem_we, reg_we, wb[1:0], dst[1:0], pc[1:0]}
    function automatic logic [11:0] model(input logic [5:0] op, input logic [5:0] fn,
                                          input logic z);
        int e = 0, b = 0, a = 0, mw = 0, rw = 0, wb = 0, d = 0, p = 0;
        if (op == 0 && fn >= 32) begin a = 1; rw = 1; d = 1; end
        else if (op == 0 && fn == 8) p = 2;
        else if (op == 0 && fn == 9) begin p = 2; rw = 1; wb = 2; d = 2; end
        else if (op >= 8 && op <= 15) begin e = (op >= 12) ? 1 : 0; b = 1; a = 2; rw = 1; end
        else if (op == 35) begin b = 1; rw = 1; wb = 1; end
        else if (op == 43) begin b = 1; mw = 1; end
        else if (op == 4) begin a = 3; p = z ? 1 : 0; end
        else if (op == 2) p = 3;
        else if (op == 3) begin p = 3; rw = 1; wb = 2; d = 2; end
        return {e[0], b[0], a[1:0], mw[0], rw[0], wb[1:0], d[1:0], p[1:0]};
    endfunction

    function automatic logic [11:0] actual();
        return {ext_sel, b_sel, alu_sel, mem_we, reg_we, wb_sel, dst_sel, pc_sel};
    endfunction

    task automatic apply(input logic [5:0] op, input logic [5:0] fn, input logic z);
        @(posedge clk);
        #1;
        opcode = op; funct = fn; zero = z;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [11:0] exp);
        checks++;
        if (actual() !== exp) begin
            errors++;
            $display("FAIL %s op=%b fn=%b z=%b actual=%b expected=%b",
                     req, opcode, funct, zero, actual(), exp);
        end
    endtask

    task automatic run(input string req, input logic [5:0] op, input logic [5:0] fn,
                       input logic z, input logic [11:0] exp);
        apply(op, fn, z);
        check(req, exp);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: all-zero inputs decode as an undefined function value
        check("R9 reset-state", 12'b0);

        // Directed checks with hand-computed control words
        run("R1", 6'd0, 6'b100001, 1'b0, 12'b0_0_01_0_1_00_01_00);
        run("R1", 6'd0, 6'b111111, 1'b1, 12'b0_0_01_0_1_00_01_00);
        run("R2", 6'b001000, 6'd0, 1'b0, 12'b0_1_10_0_1_00_00_00);
        run("R2", 6'b001011, 6'd5, 1'b1, 12'b0_1_10_0_1_00_00_00);
        run("R3", 6'b001100, 6'd0, 1'b0, 12'b1_1_10_0_1_00_00_00);
        run("R3", 6'b001111, 6'd9, 1'b0, 12'b1_1_10_0_1_00_00_00);
        run("R4", 6'b100011, 6'd0, 1'b0, 12'b0_1_00_0_1_01_00_00);
        run("R5", 6'b101011, 6'd0, 1'b1, 12'b0_1_00_1_0_00_00_00);
        run("R6", 6'b000100, 6'd0, 1'b1, 12'b0_0_11_0_0_00_00_01);
        run("R6", 6'b000100, 6'd0, 1'b0, 12'b0_0_11_0_0_00_00_00);
        run("R7", 6'b000010, 6'd0, 1'b0, 12'b0_0_00_0_0_00_00_11);
        run("R7", 6'b000011, 6'd0, 1'b1, 12'b0_0_00_0_1_10_10_11);
        run("R8", 6'd0, 6'b001000, 1'b0, 12'b0_0_00_0_0_00_00_10);
        run("R8", 6'd0, 6'b001001, 1'b1, 12'b0_0_00_0_1_10_10_10);
        run("R9", 6'd0, 6'b011111, 1'b0, 12'b0);
        run("R9", 6'b000101, 6'd0, 1'b1, 12'b0);
        run("R9", 6'b111111, 6'b100000, 1'b1, 12'b0);
        run("R9", 6'b010000, 6'd0, 1'b0, 12'b0);
        // R11: zero flag changes nothing on a non-branch kind
        run("R11", 6'b100011, 6'd0, 1'b1, 12'b0_1_00_0_1_01_00_00);

        // Sweep against the reference model (R1-R9 cases, with R10 and R11 invariants)
        for (int op = 0; op < 64; op++) begin
            for (int fn = 0; fn < 64; fn += 3) begin
                for (int z = 0; z < 2; z++) begin
                    apply(op[5:0], fn[5:0], z[0]);
                    check("R10 sweep", model(op[5:0], fn[5:0], z[0]));
                    checks++;
                    if ((mem_we && reg_we) || (!reg_we && (wb_sel != 0 || dst_sel != 0))) begin
                        errors++;
                        $display("FAIL R10 op=%b actual=%b expected=exclusive/zeroed",
                                 opcode, actual());
                    end
                end
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule